// File: doc/BRIEF.md
# ECC Memory Write Path with Scrubbing

This block sits between a host request port and a memory that stores 72-bit words: 64 data bits plus 8 check bits. On every write it computes check bits with an extended Hamming SEC-DED code. On every read it decodes the stored word. A 2-bit mode input, latched when a request is accepted, sets how far the block goes: it can do nothing, only report, correct, or correct and repair memory.

A write whose byte enables do not cover the whole word runs as a read, a merge, a re-encode and a write. Only the enabled bytes come from the host. The other bytes come from the stored word, corrected if the mode allows it. In scrub mode a read that finds a single-bit error writes the corrected word back to the same address with no host action. While a multi-step sequence runs, the block raises a busy flag and accepts no new request. Error pulses and the failing address are reported at the end of each decode.

Memory port timing: `mem_rdata_i` must hold the word read one cycle after a read request (`mem_req_o` high, `mem_we_o` low). Writes take effect at the clock edge where `mem_req_o` and `mem_we_o` are both high.

Top module: `ecc_mem_guard`

## Requirements
- R1: A write with all eight byte enables set stores the host data unchanged in memory bits 63:0 and the check byte in bits 71:64, as one memory write one cycle after acceptance.
- R2: In mode 00 the stored check byte is zero, reads return the raw stored data bits, and `sbe_o` and `mbe_o` never pulse.
- R3: In mode 01 a single flipped bit pulses `sbe_o` and a double flip pulses `mbe_o`; read data is the raw stored data bits, uncorrected.
- R4: In mode 10 a single flipped bit at any of the 72 stored positions is corrected on the read data and pulses `sbe_o`; a double flip pulses `mbe_o` and returns the raw data bits.
- R5: In mode 11 a read that finds a single-bit error returns corrected data and writes the corrected 72-bit word back to the same address; a clean read issues no memory write.
- R6: A write with any byte enable clear is a read-modify-write: bytes with the enable set (bit b covers data bits 8b+7:8b) take host data, the others keep the stored data, corrected in modes 10 and 11 and raw in modes 00 and 01.
- R7: A multi-bit error found during a read-modify-write in modes 01 to 11 pulses `mbe_o`, cancels the write, and leaves memory unchanged.
- R8: `busy_o` rises the cycle after a request is accepted (accepted when `req_i` is high and `busy_o` low) and stays high 1 cycle for a full write, 2 cycles for a read or an aborted read-modify-write, and 3 cycles for a completed read-modify-write or a scrubbed read.
- R9: `rvalid_o`, `sbe_o` and `mbe_o` are single-cycle pulses two cycles after the memory read; `sbe_o` and `mbe_o` are never high together, and `err_addr_o` holds the address of the last access that raised either.
- R10: During and right after reset, `busy_o`, `rvalid_o`, `sbe_o`, `mbe_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct and scrub |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| be_i | input | DW/8 | Byte enables for writes |
| busy_o | output | 1 | Sequence in progress; requests are not accepted |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | DW | Read data |
| sbe_o | output | 1 | Single-bit error pulse |
| mbe_o | output | 1 | Multi-bit error pulse |
| err_addr_o | output | AW | Address of the last erroring access |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write select |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW+8 | Stored word {check, data} |
| mem_rdata_i | input | DW+8 | Read word {check, data}, one cycle after the read |

## Verification
A table of words is written and read back with no flips, one data flip, one check-bit flip, a flip of the overall parity bit and double flips, in each mode. This separates correction from detection and from raw pass-through, and the check byte of mode 00 from an encoded one. A sweep of single flips over all 72 stored positions in correct mode catches any bit the code map leaves unprotected. Directed partial writes over clean, single-error and double-error words separate a corrected merge from a raw merge and from an abort. Scrub reads are compared against the clean stored word and against a count of memory writes.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_DETECT  = 2'b01,
    MODE_CORRECT = 2'b10,
    MODE_SCRUB   = 2'b11
  } ecc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WB
  } seq_state_e;

  // smallest Hamming parity count covering dw data bits
  function automatic int ham_bits(input int dw);
    for (int p = 1; p < 31; p++) begin
      if ((1 << p) >= dw + p + 1) return p;
    end
    return 31;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_guard_pkg::*;
#(
  parameter  int DW = 64,
  localparam int HW = ham_bits(DW),
  localparam int CW = DW + HW + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [HW:0]   chk_o
);

  logic [CW-1:0] cw;
  logic [HW-1:0] par;

  always_comb begin
    int j;
    cw  = '0;
    par = '0;
    j   = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = data_i[j];
        j++;
      end
    end
    for (int k = 0; k < HW; k++) begin
      for (int pos = 1; pos < CW; pos++) begin
        if (((pos >> k) & 1) == 1) par[k] = par[k] ^ cw[pos];
      end
    end
    chk_o = {(^data_i) ^ (^par), par};
  end

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_guard_pkg::*;
#(
  parameter  int DW = 64,
  localparam int HW = ham_bits(DW),
  localparam int CW = DW + HW + 1
) (
  input  logic [DW+HW:0] code_i,   // {overall, parity[HW-1:0], data}
  output logic [DW-1:0]  data_o,
  output logic           sbe_o,
  output logic           mbe_o
);

  logic [CW-1:0] cw;
  logic [HW-1:0] syn;
  logic          odd;

  always_comb begin
    int j;
    cw     = '0;
    syn    = '0;
    data_o = '0;
    sbe_o  = 1'b0;
    mbe_o  = 1'b0;
    j      = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = code_i[j];
        j++;
      end
    end
    for (int k = 0; k < HW; k++) cw[1 << k] = code_i[DW+k];
    cw[0] = code_i[DW+HW];
    for (int pos = 1; pos < CW; pos++) begin
      if (cw[pos]) syn = syn ^ HW'(pos);
    end
    odd = ^cw;
    if (odd) begin
      if (int'(syn) < CW) begin
        sbe_o   = 1'b1;
        cw[syn] = ~cw[syn];
      end else begin
        mbe_o = 1'b1;
      end
    end else if (syn != '0) begin
      mbe_o = 1'b1;
    end
    j = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        data_o[j] = cw[pos];
        j++;
      end
    end
  end

endmodule

// File: rtl/ecc_merge.sv
module ecc_merge #(
  parameter  int DW = 64,
  localparam int BW = DW / 8
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] new_i,
  input  logic [BW-1:0] be_i,
  output logic [DW-1:0] data_o
);

  for (genvar b = 0; b < BW; b++) begin : g_byte
    assign data_o[8*b +: 8] = be_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
  end

endmodule

// File: rtl/ecc_mem_guard.sv
module ecc_mem_guard
  import ecc_guard_pkg::*;
#(
  parameter  int DW    = 64,
  parameter  int AW    = 16,
  localparam int HW    = ham_bits(DW),
  localparam int CHK_W = HW + 1,
  localparam int BW    = DW / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [BW-1:0]       be_i,
  output logic                busy_o,
  output logic                rvalid_o,
  output logic [DW-1:0]       rdata_o,
  output logic                sbe_o,
  output logic                mbe_o,
  output logic [AW-1:0]       err_addr_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DW+CHK_W-1:0] mem_wdata_o,
  input  logic [DW+CHK_W-1:0] mem_rdata_i
);

  seq_state_e    state_q, state_d;
  ecc_mode_e     mode_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [BW-1:0] be_q;

  logic             accept;
  logic             chk_on, fix_on;
  logic [DW-1:0]    dec_data, sel_data, merged;
  logic             dec_sbe, dec_mbe, flag_sbe, flag_mbe;
  logic [CHK_W-1:0] enc_chk;

  assign accept = req_i && (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);
  assign chk_on = (mode_q != MODE_OFF);
  assign fix_on = (mode_q == MODE_CORRECT) || (mode_q == MODE_SCRUB);

  ecc_dec #(.DW(DW)) u_dec (
    .code_i (mem_rdata_i),
    .data_o (dec_data),
    .sbe_o  (dec_sbe),
    .mbe_o  (dec_mbe)
  );

  assign sel_data = fix_on ? dec_data : mem_rdata_i[DW-1:0];
  assign flag_sbe = chk_on && dec_sbe;
  assign flag_mbe = chk_on && dec_mbe;

  ecc_merge #(.DW(DW)) u_merge (
    .old_i  (sel_data),
    .new_i  (data_q),
    .be_i   (be_q),
    .data_o (merged)
  );

  ecc_enc #(.DW(DW)) u_enc (
    .data_i (data_q),
    .chk_o  (enc_chk)
  );

  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WB);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = {chk_on ? enc_chk : {CHK_W{1'b0}}, data_q};

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_i) state_d = (we_i && (&be_i)) ? ST_WB : ST_RD;
      ST_RD:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (!we_q) state_d = (mode_q == MODE_SCRUB && dec_sbe) ? ST_WB : ST_IDLE;
        else       state_d = flag_mbe ? ST_IDLE : ST_WB;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_OFF;
      we_q       <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      be_q       <= '0;
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
      sbe_o      <= 1'b0;
      mbe_o      <= 1'b0;
      err_addr_o <= '0;
    end else begin
      state_q  <= state_d;
      rvalid_o <= 1'b0;
      sbe_o    <= 1'b0;
      mbe_o    <= 1'b0;
      if (accept) begin
        mode_q <= ecc_mode_e'(mode_i);
        we_q   <= we_i;
        addr_q <= addr_i;
        data_q <= wdata_i;
        be_q   <= be_i;
      end
      if (state_q == ST_WAIT) begin
        sbe_o <= flag_sbe;
        mbe_o <= flag_mbe;
        if (flag_sbe || flag_mbe) err_addr_o <= addr_q;
        if (!we_q) begin
          rvalid_o <= 1'b1;
          rdata_o  <= sel_data;
          data_q   <= dec_data;   // scrub source
        end else begin
          data_q <= merged;
        end
      end
    end
  end

  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);

  p_flags_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbe_o && mbe_o));

  p_rvalid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_off_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && mode_q == MODE_OFF) |=> (!sbe_o && !mbe_o));

  p_scrub_writeback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && sbe_o && mode_q == MODE_SCRUB) |-> (mem_req_o && mem_we_o));

  p_rmw_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbe_o && !rvalid_o) |-> !mem_req_o);

  p_no_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mem_addr_o) || !busy_o || $past(state_q == ST_IDLE));

endmodule

// File: tb/ecc_mem_guard_bench.sv
`timescale 1ns/1ps
module ecc_mem_guard_bench;

  localparam int DW = 64;
  localparam int AW = 4;
  localparam int MW = 72;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [7:0]    be = '0;
  logic          busy_o, rvalid_o, sbe_o, mbe_o;
  logic [DW-1:0] rdata_o;
  logic [AW-1:0] err_addr_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [MW-1:0] mem_wdata_o;
  logic [MW-1:0] rd_q = '0;

  logic [MW-1:0] mem_q [16];
  logic          inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [MW-1:0] inj_mask = '0;
  int            wr_cnt = 0;
  int            n_chk = 0;
  int            n_err = 0;

  always #10 clk = ~clk;

  ecc_mem_guard #(.DW(DW), .AW(AW)) u_ecc_mem_guard (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .busy_o(busy_o),
    .rvalid_o(rvalid_o), .rdata_o(rdata_o), .sbe_o(sbe_o), .mbe_o(mbe_o),
    .err_addr_o(err_addr_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(rd_q)
  );

  always @(posedge clk) begin
    if (inj_en) mem_q[inj_addr] <= mem_q[inj_addr] ^ inj_mask;
    else if (mem_req_o && mem_we_o) begin
      mem_q[mem_addr_o] <= mem_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_req_o && !mem_we_o) rd_q <= mem_q[mem_addr_o];
  end

  // {mode, addr, data, nflip, flip_a, flip_b}
  localparam logic [85:0] VEC [NV] = '{
    {2'd2, 4'd0, 64'h0123456789ABCDEF, 2'd0, 7'd0,  7'd0},
    {2'd2, 4'd1, 64'hFFFFFFFFFFFFFFFF, 2'd1, 7'd0,  7'd0},
    {2'd2, 4'd2, 64'h0000000000000000, 2'd1, 7'd70, 7'd0},
    {2'd2, 4'd3, 64'hA5A5A5A5A5A5A5A5, 2'd2, 7'd5,  7'd40},
    {2'd1, 4'd4, 64'hDEADBEEFCAFEF00D, 2'd1, 7'd63, 7'd0},
    {2'd1, 4'd5, 64'h1122334455667788, 2'd2, 7'd10, 7'd71},
    {2'd0, 4'd6, 64'h0F0F0F0F0F0F0F0F, 2'd1, 7'd3,  7'd0},
    {2'd3, 4'd7, 64'h8000000000000001, 2'd0, 7'd0,  7'd0},
    {2'd2, 4'd8, 64'h5555555555555555, 2'd1, 7'd71, 7'd0},
    {2'd3, 4'd9, 64'h13579BDF02468ACE, 2'd2, 7'd64, 7'd65}
  };

  task automatic check(input bit ok, input string tag, input logic [MW-1:0] act,
                       input logic [MW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [7:0] b, input logic [1:0] m,
                        output logic [DW-1:0] rd, output bit s, output bit mb,
                        output int bc);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b; mode = m;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    rd = '0; s = 1'b0; mb = 1'b0; bc = 0;
    for (int i = 0; i < 20; i++) begin
      s  = s | sbe_o;
      mb = mb | mbe_o;
      if (rvalid_o) rd = rdata_o;
      if (!busy_o) break;
      bc++;
      @(negedge clk);
    end
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [MW-1:0] msk);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_mask = msk;
    @(posedge clk);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, exp_d;
    logic [MW-1:0] msk, gold;
    bit s, mb;
    int bc, w0;

    repeat (2) @(negedge clk);
    // R10 reset state
    check(!busy_o && !rvalid_o && !sbe_o && !mbe_o && !mem_req_o, "R10 reset outputs",
          {busy_o, rvalid_o, sbe_o, mbe_o, mem_req_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !mem_req_o, "R10 after release", {busy_o, mem_req_o}, '0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] vm = VEC[v][85:84];
      logic [3:0] va = VEC[v][83:80];
      logic [63:0] vd = VEC[v][79:16];
      logic [1:0] nf = VEC[v][15:14];
      msk = '0;
      if (nf >= 2'd1) msk = msk | (72'd1 << VEC[v][13:7]);
      if (nf == 2'd2) msk = msk | (72'd1 << VEC[v][6:0]);
      access(1'b1, va, vd, 8'hFF, vm, rd, s, mb, bc);
      check(mem_q[va][63:0] == vd, "R1 stored data", mem_q[va], {8'h0, vd});
      check(bc == 1, "R8 full write busy", bc, 1);
      if (vm == 2'd0)
        check(mem_q[va][71:64] == 8'h0, "R2 zero check byte", mem_q[va][71:64], 0);
      inject(va, msk);
      access(1'b0, va, '0, 8'h00, vm, rd, s, mb, bc);
      exp_d = (vm[1] && nf == 2'd1) ? vd : (vd ^ msk[63:0]);
      check(rd == exp_d, vm == 2'd1 ? "R3 read data" : (vm == 2'd0 ? "R2 read data" : "R4 read data"),
            rd, exp_d);
      check(s == (vm != 2'd0 && nf == 2'd1), vm == 2'd1 ? "R3 sbe" : "R4 sbe", s, (vm != 2'd0 && nf == 2'd1));
      check(mb == (vm != 2'd0 && nf == 2'd2), vm == 2'd1 ? "R3 mbe" : "R4 mbe", mb, (vm != 2'd0 && nf == 2'd2));
    end

    // R4 single flip sweep over all stored positions
    for (int k = 0; k < MW; k++) begin
      access(1'b1, 4'd1, 64'hC3A5_0F1E_9876_5A3C, 8'hFF, 2'd2, rd, s, mb, bc);
      inject(4'd1, 72'd1 << k);
      access(1'b0, 4'd1, '0, 8'h00, 2'd2, rd, s, mb, bc);
      check(rd == 64'hC3A5_0F1E_9876_5A3C && s && !mb, "R4 sweep position",
            {s, mb, rd}, {2'b10, 64'hC3A5_0F1E_9876_5A3C});
    end

    // R5 scrub write-back
    access(1'b1, 4'd10, 64'hFEDC_BA98_7654_3210, 8'hFF, 2'd3, rd, s, mb, bc);
    gold = mem_q[10];
    inject(4'd10, 72'd1 << 20);
    w0 = wr_cnt;
    access(1'b0, 4'd10, '0, 8'h00, 2'd3, rd, s, mb, bc);
    check(rd == 64'hFEDC_BA98_7654_3210 && s, "R5 scrub read", rd, 64'hFEDC_BA98_7654_3210);
    check(mem_q[10] == gold, "R5 memory repaired", mem_q[10], gold);
    check(wr_cnt - w0 == 1, "R5 one write-back", wr_cnt - w0, 1);
    check(bc == 3, "R8 scrub busy", bc, 3);
    check(err_addr_o == 4'd10, "R9 error address", err_addr_o, 10);
    w0 = wr_cnt;
    access(1'b0, 4'd10, '0, 8'h00, 2'd3, rd, s, mb, bc);
    check(wr_cnt == w0 && !s, "R5 clean read no write", wr_cnt - w0, 0);
    check(bc == 2, "R8 read busy", bc, 2);

    // R6 partial write merge
    access(1'b1, 4'd11, 64'h1111_1111_1111_1111, 8'hFF, 2'd2, rd, s, mb, bc);
    access(1'b1, 4'd11, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F, 2'd2, rd, s, mb, bc);
    check(bc == 3, "R8 rmw busy", bc, 3);
    access(1'b0, 4'd11, '0, 8'h00, 2'd2, rd, s, mb, bc);
    check(rd == 64'h1111_1111_AAAA_AAAA, "R6 byte merge", rd, 64'h1111_1111_AAAA_AAAA);

    // R6 corrected merge in mode 10
    access(1'b1, 4'd12, 64'h0, 8'hFF, 2'd2, rd, s, mb, bc);
    inject(4'd12, 72'd1 << 60);
    access(1'b1, 4'd12, 64'hFF, 8'h01, 2'd2, rd, s, mb, bc);
    check(s && !mb, "R6 rmw sbe flagged", {s, mb}, 2'b10);
    access(1'b0, 4'd12, '0, 8'h00, 2'd2, rd, s, mb, bc);
    check(rd == 64'hFF && !s && !mb, "R6 corrected merge", rd, 64'hFF);

    // R6 raw merge in mode 01
    access(1'b1, 4'd13, 64'h0, 8'hFF, 2'd1, rd, s, mb, bc);
    inject(4'd13, 72'd1 << 60);
    access(1'b1, 4'd13, 64'hFF, 8'h01, 2'd1, rd, s, mb, bc);
    access(1'b0, 4'd13, '0, 8'h00, 2'd1, rd, s, mb, bc);
    check(rd == 64'h1000_0000_0000_00FF && !s, "R6 raw merge", rd, 64'h1000_0000_0000_00FF);

    // R7 abort on multi-bit error
    access(1'b1, 4'd14, 64'h0BAD_F00D_0BAD_F00D, 8'hFF, 2'd2, rd, s, mb, bc);
    inject(4'd14, 72'h6);
    gold = mem_q[14];
    w0 = wr_cnt;
    access(1'b1, 4'd14, '1, 8'hF0, 2'd2, rd, s, mb, bc);
    check(mb && !s, "R7 mbe flagged", {s, mb}, 2'b01);
    check(mem_q[14] == gold && wr_cnt == w0, "R7 memory unchanged", mem_q[14], gold);
    check(bc == 2, "R8 abort busy", bc, 2);
    check(err_addr_o == 4'd14, "R9 error address rmw", err_addr_o, 14);

    // R2 partial write in mode 00
    access(1'b1, 4'd15, 64'h0, 8'hFF, 2'd0, rd, s, mb, bc);
    access(1'b1, 4'd15, 64'hFF00_0000_0000_0000, 8'h80, 2'd0, rd, s, mb, bc);
    check(mem_q[15] == {8'h0, 64'hFF00_0000_0000_0000}, "R2 mode off rmw", mem_q[15],
          {8'h0, 64'hFF00_0000_0000_0000});

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule